// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each incoming Ethernet frame, whether the frame is kept or dropped, judging only by its destination address. Software programs it by streaming a setup frame through it. The setup frame is split into fixed 12-byte slots, and the block builds one 6-byte address from each complete slot. Any address whose group bit is set is thrown away. Every other address is appended to a packed table of unicast addresses, and the table reports how many entries it holds.

Once loading is finished, the six destination bytes of each received frame are presented one per cycle. One cycle after the sixth byte, the block raises a one-cycle decision pulse together with an accept flag. A frame is accepted in any of three cases:
- the accept-all mode input is high;
- the destination is a group address;
- the destination exactly equals a stored entry.

Loading and filtering never run at the same time. While a load is in progress, a busy output is high and destination bytes are ignored.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `load_busy`, `entry_count` and `decide_valid` are all 0.
- R2: A `setup_start` pulse empties the table, so `entry_count` reads 0 one cycle later. It also raises `load_busy` in that same cycle.
- R3: Byte offsets within a 12-byte slot are counted from 0. The stored address takes slot offsets 0, 1, 4, 5, 8 and 9 as destination bytes 0 to 5, in that order, and every other offset is ignored.
- R4: The group bit is bit 0 of destination byte 0. A slot whose extracted address has this bit set is not stored. Stored entries fill the table in slot order, and `entry_count` equals the number stored.
- R5: Loading ends in the cycle after either the 192nd setup byte or a byte marked with `setup_last`. A slot that is not complete when loading ends is not stored.
- R6: `decide_valid` is high for exactly the one cycle that follows the cycle carrying the sixth destination byte.
- R7: When `accept_all` is high at the sixth destination byte, the frame is accepted.
- R8: A destination whose group bit is set is accepted, even though group addresses are never stored.
- R9: Any other destination is accepted only when it equals a stored entry in all six bytes. A difference in a single byte rejects it.
- R10: Destination bytes that arrive while `load_busy` is high produce no decision. Setup bytes that arrive while `load_busy` is low leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accept_all | input | 1 | Mode bit: accept every frame |
| setup_start | input | 1 | Pulse: empty the table and begin loading |
| setup_valid | input | 1 | A setup byte is present this cycle |
| setup_byte | input | 8 | Setup frame byte |
| setup_last | input | 1 | Marks the final byte of a short setup frame |
| dst_valid | input | 1 | A destination byte is present this cycle |
| dst_byte | input | 8 | Destination address byte, byte 0 first |
| load_busy | output | 1 | Setup frame is being loaded |
| entry_count | output | 5 | Number of stored unicast entries |
| decide_valid | output | 1 | One-cycle pulse: decision is ready |
| accept | output | 1 | Decision: 1 keeps the frame, 0 drops it |

## Verification
The assertions assume that destination bytes arrive in complete groups of six. They also assume that `setup_start` never falls inside such a group, because the byte counter in the matcher is never realigned. The stimulus follows both rules: every destination frame is sent as six consecutive bytes, and new loads start only between frames. Destination bytes are deliberately injected during loading, where the design gates them off. Setup bytes are sent while the block is idle, to show that they have no effect.

// File: rtl/rx_filter_pkg.sv
`timescale 1ns/1ps
package rx_filter_pkg;
  localparam int ADDR_BYTES = 6;
  typedef logic [ADDR_BYTES-1:0][7:0] mac_t;
endpackage

// File: rtl/setup_slot_loader.sv
`timescale 1ns/1ps
module setup_slot_loader
  import rx_filter_pkg::*;
#(
  parameter int SLOTS      = 16,
  parameter int SLOT_BYTES = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  input  logic       byte_last,
  output logic       busy,
  output logic       wr_en,
  output mac_t       wr_data
);
  localparam int OW = $clog2(SLOT_BYTES);
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [OW-1:0] off;
  logic [SW-1:0] slot;
  mac_t          asm_q;
  logic          take, pick, slot_end, frame_end;
  logic [2:0]    pos;

  // Address bytes sit at offsets 0,1,4,5,8,9: pairs whose offset bit 1 is clear.
  assign take      = busy && byte_valid && !start;
  assign pick      = (off < OW'(10)) && !off[1];
  assign pos       = {off[3:2], off[0]};
  assign slot_end  = (off == OW'(SLOT_BYTES - 1));
  assign frame_end = take && (byte_last || (slot_end && slot == SW'(SLOTS - 1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      off   <= '0;
      slot  <= '0;
      asm_q <= '0;
    end else if (start) begin
      busy <= 1'b1;
      off  <= '0;
      slot <= '0;
    end else if (take) begin
      if (pick) asm_q[pos] <= byte_data;
      if (slot_end) begin
        off  <= '0;
        slot <= slot + 1'b1;
      end else begin
        off <= off + 1'b1;
      end
      if (frame_end) busy <= 1'b0;
    end
  end

  // Offset 9 is the last address byte, so the address is complete at slot end.
  assign wr_en   = take && slot_end && !asm_q[0][0];
  assign wr_data = asm_q;

  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && off == '0))
    else $error("start did not open a load");
  a_r5_marked_end: assert property (@(posedge clk) disable iff (rst)
    (busy && byte_valid && byte_last && !start) |=> !busy)
    else $error("load did not end on marked byte");
endmodule

// File: rtl/unicast_table.sv
`timescale 1ns/1ps
module unicast_table
  import rx_filter_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          wr_en,
  input  mac_t          wr_data,
  output mac_t          entries [DEPTH],
  output logic [CW-1:0] count
);
  // Storage carries no reset; entries at or above count are masked by users.
  always_ff @(posedge clk) begin
    if (wr_en && !clear && count < CW'(DEPTH)) entries[count[CW-2:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clear)                          count <= '0;
    else if (wr_en && count < CW'(DEPTH))      count <= count + 1'b1;
  end

  a_r2_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count == '0))
    else $error("clear left entries");
  a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (count == $past(count) || count == $past(count) + 1'b1))
    else $error("count jumped");
  always @(posedge clk) begin
    if (!rst) begin
      a_r4_bound: assert (count <= CW'(DEPTH)) else $error("count overflow");
    end
  end
endmodule

// File: rtl/dest_matcher.sv
`timescale 1ns/1ps
module dest_matcher
  import rx_filter_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept_all,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  input  mac_t          entries [DEPTH],
  input  logic [CW-1:0] count,
  output logic          decide_valid,
  output logic          accept
);
  logic [2:0]       idx;
  logic [DEPTH-1:0] hit, hit_nx;
  logic             grp, grp_nx, last;

  assign last   = byte_valid && (idx == 3'(ADDR_BYTES - 1));
  assign grp_nx = (idx == 3'd0) ? byte_data[0] : grp;

  // One byte comparator per entry; a per-entry flag survives while bytes agree.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cmp
    assign hit_nx[gi] = (entries[gi][idx] == byte_data)
                        && ((idx == 3'd0) || hit[gi])
                        && (CW'(gi) < count);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx          <= '0;
      hit          <= '0;
      grp          <= 1'b0;
      decide_valid <= 1'b0;
      accept       <= 1'b0;
    end else begin
      decide_valid <= last;
      if (byte_valid) begin
        hit <= hit_nx;
        grp <= grp_nx;
        idx <= last ? 3'd0 : idx + 3'd1;
        if (last) accept <= accept_all || grp_nx || (|hit_nx);
      end
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    decide_valid |=> !decide_valid)
    else $error("decision pulse too long");
  a_r7_all_mode: assert property (@(posedge clk) disable iff (rst)
    (last && accept_all) |=> (decide_valid && accept))
    else $error("accept-all frame rejected");
endmodule

// File: rtl/rx_addr_filter.sv
`timescale 1ns/1ps
module rx_addr_filter
  import rx_filter_pkg::*;
#(
  parameter int SLOTS      = 16,
  parameter int SLOT_BYTES = 12,
  localparam int CW        = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept_all,
  input  logic          setup_start,
  input  logic          setup_valid,
  input  logic [7:0]    setup_byte,
  input  logic          setup_last,
  input  logic          dst_valid,
  input  logic [7:0]    dst_byte,
  output logic          load_busy,
  output logic [CW-1:0] entry_count,
  output logic          decide_valid,
  output logic          accept
);
  logic wr_en;
  mac_t wr_data;
  mac_t entries [SLOTS];
  logic dst_take;

  setup_slot_loader #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_loader (
    .clk(clk), .rst(rst), .start(setup_start), .byte_valid(setup_valid),
    .byte_data(setup_byte), .byte_last(setup_last), .busy(load_busy),
    .wr_en(wr_en), .wr_data(wr_data)
  );

  unicast_table #(.DEPTH(SLOTS), .CW(CW)) u_table (
    .clk(clk), .rst(rst), .clear(setup_start), .wr_en(wr_en),
    .wr_data(wr_data), .entries(entries), .count(entry_count)
  );

  assign dst_take = dst_valid && !load_busy;

  dest_matcher #(.DEPTH(SLOTS), .CW(CW)) u_match (
    .clk(clk), .rst(rst), .accept_all(accept_all), .byte_valid(dst_take),
    .byte_data(dst_byte), .entries(entries), .count(entry_count),
    .decide_valid(decide_valid), .accept(accept)
  );

  a_r10_quiet_while_loading: assert property (@(posedge clk) disable iff (rst)
    (load_busy && $past(load_busy)) |-> !decide_valid)
    else $error("decision during load");
endmodule

// File: tb/rx_addr_filter_tb.sv
`timescale 1ns/1ps
module rx_addr_filter_tb;
  typedef logic [5:0][7:0] addr_t;

  logic clk = 0, rst = 1;
  logic accept_all = 0, setup_start = 0, setup_valid = 0, setup_last = 0;
  logic [7:0] setup_byte = 0, dst_byte = 0;
  logic dst_valid = 0;
  logic load_busy, decide_valid, accept;
  logic [4:0] entry_count;

  rx_addr_filter u_dut (
    .clk(clk), .rst(rst), .accept_all(accept_all), .setup_start(setup_start),
    .setup_valid(setup_valid), .setup_byte(setup_byte), .setup_last(setup_last),
    .dst_valid(dst_valid), .dst_byte(dst_byte), .load_busy(load_busy),
    .entry_count(entry_count), .decide_valid(decide_valid), .accept(accept)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] sf [192];
  addr_t slot_addr [16];
  logic  slot_grp [16];
  addr_t exp_tab [16];
  int    exp_cnt = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(input int seed);
    for (int i = 0; i < 16; i++) begin
      slot_grp[i] = ((i * 5 + seed) % 3) == 0;
      for (int k = 0; k < 6; k++)
        slot_addr[i][k] = (k == 0) ? {i[3:0], seed[0], 2'b00, slot_grp[i]}
                                   : 8'(8'h11 * k + seed * 8'h50 + i);
      for (int o = 0; o < 12; o++) sf[i*12+o] = 8'hC0 | 8'(i);
      for (int k = 0; k < 6; k++) sf[i*12 + (k/2)*4 + (k%2)] = slot_addr[i][k];
    end
  endtask

  task automatic expect_slots(input int nslots);
    exp_cnt = 0;
    for (int i = 0; i < nslots; i++)
      if (!slot_grp[i]) begin exp_tab[exp_cnt] = slot_addr[i]; exp_cnt++; end
  endtask

  function automatic logic model(input addr_t d, input logic pm);
    logic r = pm | d[0][0];
    for (int j = 0; j < 16; j++) if (j < exp_cnt && exp_tab[j] == d) r = 1;
    return r;
  endfunction

  task automatic load(input int nbytes, input logic mark);
    int pulses = 0;
    setup_start = 1;
    @(negedge clk);
    setup_start = 0;
    check("R2 busy after start", load_busy, 1);
    check("R2 table emptied", entry_count, 0);
    for (int b = 0; b < nbytes; b++) begin
      setup_valid = 1; setup_byte = sf[b]; setup_last = mark && (b == nbytes - 1);
      dst_valid = 1; dst_byte = 8'(b * 3);
      @(negedge clk);
      if (decide_valid) pulses++;
    end
    setup_valid = 0; setup_last = 0; dst_valid = 0;
    check("R10 no decision while loading", pulses, 0);
    check("R5 load finished", load_busy, 0);
  endtask

  task automatic run_dest(input addr_t d, input logic pm, input string req);
    accept_all = pm;
    for (int k = 0; k < 6; k++) begin
      dst_valid = 1; dst_byte = d[k];
      @(negedge clk);
      if (k < 5 && decide_valid) check({req, " R6 early"}, 1, 0);
    end
    dst_valid = 0;
    check({req, " R6 pulse"}, decide_valid, 1);
    check(req, accept, model(d, pm));
    @(negedge clk);
    check({req, " R6 one cycle"}, decide_valid, 0);
    accept_all = 0;
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 16; i++) begin
      addr_t d = slot_addr[i];
      run_dest(d, 0, slot_grp[i] ? {tag, " R8 group"} : {tag, " R3 R9 stored"});
      d[i % 6] = d[i % 6] ^ 8'h40;
      run_dest(d, 0, {tag, " R9 one byte off"});
      run_dest(d, 1, {tag, " R7 accept all"});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", load_busy, 0);
    check("R1 count", entry_count, 0);
    check("R1 decide", decide_valid, 0);
    rst = 0;
    @(negedge clk);

    build(0); expect_slots(16);
    load(192, 0);
    check("R4 count seed0", entry_count, exp_cnt);
    sweep("s0");

    build(1); expect_slots(16);
    load(192, 1);
    check("R4 count seed1", entry_count, exp_cnt);
    sweep("s1");

    // Short frame: 2 full slots plus a partial third holding offsets 0..5.
    build(2); expect_slots(2);
    load(30, 1);
    check("R5 short count", entry_count, exp_cnt);
    for (int i = 0; i < 3; i++)
      run_dest(slot_addr[i], 0, i == 2 ? "R5 partial slot" : "R5 kept slot");

    // Idle setup bytes: a unicast slot without start must not be stored.
    build(3);
    for (int b = 0; b < 24; b++) begin
      setup_valid = 1; setup_byte = sf[b]; @(negedge clk);
    end
    setup_valid = 0;
    check("R10 idle setup bytes", entry_count, exp_cnt);
    run_dest(slot_addr[1], 0, "R10 idle slot not stored");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule